// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs one 8-bit general-purpose port. A small synchronous register bus reaches two registers: a direction register, where a 1 makes a pin an output, and an output data register. Each pin is shared between plain port use, a timer compare output, a timer capture input and the output of a pulse-output unit. The timer and pulse-output units sit outside the block. Each pin has its own set of control inputs from those units: a PWM flag, a 3-bit I/O control field and a pulse enable. The block turns these controls into a drive value and an output enable for every pin.

Incoming pin levels go through a two-flop synchronizer. The synchronized levels feed the data-register read path and the capture signal sent to the timer.

A small power-mode state machine tracks the two standby inputs. Its states are RUN, SOFT (software standby) and HARD (hardware standby). Its transitions are:
- go_hard: from any state when `hstby` is high.
- go_soft: from RUN or HARD when `sstby` is high and `hstby` is low.
- wake: from SOFT or HARD to RUN when both standby inputs are low.

In SOFT, register contents and pin drive are kept. In HARD, both registers are cleared and every output is turned off.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction and data registers read 0x00, and every `pin_oe` bit is 0.
- R2: A write with `bus_we`=1 stores `bus_wdata` at the clock edge. Address 0 selects the direction register and address 1 selects the data register. Reads use the same two addresses. The new value shows on `bus_rdata` right after that edge.
- R3: A read at address 1 returns, for each pin, the stored data bit if its direction bit is 1, and the synchronized pin level if its direction bit is 0.
- R4: A change on `pin_in` first reaches `bus_rdata` and `cap_in` after the second rising clock edge.
- R5: A pin is owned by the timer when its PWM flag is 1, or when its I/O control field has bit 2 = 0 and bits 1:0 not equal to 00. A timer-owned pin drives `tmr_out` with `pin_oe`=1, whatever its direction and pulse-enable settings.
- R6: A pin the timer does not own works as follows:
  - direction bit 0: `pin_oe`=0 and `pin_out`=0;
  - direction bit 1, pulse enable 0: the pin drives its data bit with `pin_oe`=1;
  - direction bit 1, pulse enable 1: the pin drives `pulse_val` with `pin_oe`=1.
- R7: `cap_in` for a pin equals its synchronized level when its I/O control bit 2 = 1 and its PWM flag = 0. Otherwise `cap_in` is 0.
- R8: While `sstby` is high, bus writes are ignored. Both registers keep their contents, and pin drive continues as configured.
- R9: While `hstby` is high, bus writes are ignored and both registers are cleared at each clock edge. From the edge after `hstby` is first sampled high, every `pin_oe` and `pin_out` bit is 0.
- R10: When `hstby` and `sstby` are both high, hardware standby takes precedence. After both return low, normal operation resumes from the next edge, with cleared registers if hardware standby was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hstby | input | 1 | Hardware standby request |
| sstby | input | 1 | Software standby request |
| bus_addr | input | 2 | Register address (0 direction, 1 data) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |
| tmr_pwm | input | 8 | Per-pin timer PWM flag |
| tmr_ioc | input | 24 | Per-pin 3-bit timer I/O control, pin i at bits 3i+2:3i |
| tmr_out | input | 8 | Timer compare output values |
| cap_in | output | 8 | Synchronized capture inputs to the timer |
| pulse_en | input | 8 | Per-pin pulse-output enable |
| pulse_val | input | 8 | Pulse-output unit values |

## Verification
Timing of each result:
- Pin function selection (R5, R6) and read data (R2, R3) are combinational from the registers and the controls. The bench checks them shortly after the edge on which a write lands, or right after the controls change.
- Pin levels pass two flops. The bench samples after one edge to see the old value, and after the second edge to see the new one.
- Standby effects need the power-mode register and the register clear. The bench checks them after the first edge with the standby input high.

The pin function sweep gives each pin its own rotating 6-bit configuration (PWM, I/O control, pulse enable, direction). Over the run, every pin covers all 64 combinations.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_SOFT = 2'd1,
        PM_HARD = 2'd2
    } pwr_mode_e;

    localparam int unsigned ADDR_DIR = 0;
    localparam int unsigned ADDR_DAT = 1;

    // Timer claims the pin: PWM mode, or compare-output code in the control field
    function automatic logic timer_owns(input logic pwm, input logic [2:0] ioc);
        return pwm | (~ioc[2] & (ioc[1:0] != 2'b00));
    endfunction

endpackage

// File: rtl/gpio_pwr_fsm.sv
module gpio_pwr_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hstby,
    input  logic sstby,
    output logic wr_ok,
    output logic clr_regs,
    output logic drive_off
);

    pwr_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN:  if (hstby) state_d = PM_HARD;
                     else if (sstby) state_d = PM_SOFT;
            PM_SOFT: if (hstby) state_d = PM_HARD;
                     else if (!sstby) state_d = PM_RUN;
            PM_HARD: if (!hstby) state_d = sstby ? PM_SOFT : PM_RUN;
            default: state_d = PM_RUN;
        endcase
    end

    always_comb begin
        wr_ok     = !hstby && !sstby;
        clr_regs  = hstby;
        drive_off = (state_q == PM_HARD);
    end

    // R10: hardware standby wins over software standby
    a_r10_hard_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hstby && sstby) |=> (state_q == PM_HARD));

    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!hstby && !sstby) |=> (state_q == PM_RUN));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s1, s2;
    logic [1:0]   age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1  <= '0;
            s2  <= '0;
            age <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
            if (age != 2'd2) age <= age + 2'd1;
        end
    end

    assign q = s2;

    // R4: output is the input two edges earlier
    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (s2 == $past(d, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  ddr,
    output logic [W-1:0]  dr
);

    logic wr_dir, wr_dat;

    always_comb begin
        wr_dir = we && wr_ok && (addr == AW'(ADDR_DIR));
        wr_dat = we && wr_ok && (addr == AW'(ADDR_DAT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr <= '0;
            dr  <= '0;
        end else if (clr) begin
            ddr <= '0;
            dr  <= '0;
        end else begin
            if (wr_dir) ddr <= wdata;
            if (wr_dat) dr  <= wdata;
        end
    end

    // R9: hardware standby clears both registers
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ddr == '0 && dr == '0));

    // R8: blocked writes leave registers untouched
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !clr) |=> ($stable(ddr) && $stable(dr)));

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           drive_off,
    input  logic [W-1:0]   ddr,
    input  logic [W-1:0]   dr,
    input  logic [W-1:0]   pwm,
    input  logic [3*W-1:0] ioc,
    input  logic [W-1:0]   pe,
    input  logic [W-1:0]   tout,
    input  logic [W-1:0]   pval,
    input  logic [W-1:0]   lvl,
    output logic [W-1:0]   out,
    output logic [W-1:0]   oe,
    output logic [W-1:0]   cap
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [2:0] ctl;
        logic       own;
        assign ctl = ioc[3*i +: 3];
        assign own = timer_owns(pwm[i], ctl);

        always_comb begin
            out[i] = 1'b0;
            oe[i]  = 1'b0;
            if (!drive_off) begin
                if (own) begin
                    out[i] = tout[i];
                    oe[i]  = 1'b1;
                end else if (ddr[i]) begin
                    out[i] = pe[i] ? pval[i] : dr[i];
                    oe[i]  = 1'b1;
                end
            end
            cap[i] = (ctl[2] && !pwm[i]) ? lvl[i] : 1'b0;
        end

        // R5: PWM flag hands the pin to the timer
        a_r5_pwm_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (!drive_off && pwm[i]) |-> (oe[i] && out[i] == tout[i]));

        // R6: non-timer pin with direction 0 is not driven
        a_r6_input_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwm[i] && (ctl[2] || ctl[1:0] == 2'b00) && !ddr[i]) |-> !oe[i]);
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hstby,
    input  logic           sstby,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    input  logic [W-1:0]   pin_in,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_oe,
    input  logic [W-1:0]   tmr_pwm,
    input  logic [3*W-1:0] tmr_ioc,
    input  logic [W-1:0]   tmr_out,
    output logic [W-1:0]   cap_in,
    input  logic [W-1:0]   pulse_en,
    input  logic [W-1:0]   pulse_val
);

    logic         wr_ok, clr_regs, drive_off;
    logic [W-1:0] ddr, dr, lvl;

    gpio_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hstby     (hstby),
        .sstby     (sstby),
        .wr_ok     (wr_ok),
        .clr_regs  (clr_regs),
        .drive_off (drive_off)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .clr   (clr_regs),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ddr   (ddr),
        .dr    (dr)
    );

    gpio_pinmux #(.W(W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_off (drive_off),
        .ddr       (ddr),
        .dr        (dr),
        .pwm       (tmr_pwm),
        .ioc       (tmr_ioc),
        .pe        (pulse_en),
        .tout      (tmr_out),
        .pval      (pulse_val),
        .lvl       (lvl),
        .out       (pin_out),
        .oe        (pin_oe),
        .cap       (cap_in)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_DIR))      bus_rdata = ddr;
        else if (bus_addr == AW'(ADDR_DAT)) bus_rdata = (dr & ddr) | (lvl & ~ddr);
    end

    // R9: outputs dark one edge after hardware standby is seen
    a_r9_dark: assert property (@(posedge clk) disable iff (!rst_n)
        hstby |=> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hstby = 1'b0, sstby = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [7:0]   pin_in = '0, pin_out, pin_oe;
    logic [7:0]   tmr_pwm = '0, tmr_out = '0, cap_in;
    logic [23:0]  tmr_ioc = '0;
    logic [7:0]   pulse_en = '0, pulse_val = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    gpio_mux_port i_gpio_mux_port (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // Expected pin result from R5/R6/R7, given one pin's 6-bit config k
    function automatic logic [2:0] pin_exp(input logic [5:0] k, input logic d,
                                           input logic t, input logic p, input logic lv);
        logic pwm, pe, dd, own, o, e, c;
        logic [2:0] ic;
        pwm = k[0]; ic = k[3:1]; pe = k[4]; dd = k[5];
        own = pwm || (ic[2] == 1'b0 && ic[1:0] != 2'b00);
        if (own) begin o = t; e = 1'b1; end
        else if (dd) begin o = pe ? p : d; e = 1'b1; end
        else begin o = 1'b0; e = 1'b0; end
        c = (ic[2] && !pwm) ? lv : 1'b0;
        return {c, e, o};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(2'd0, "R1 dir", 8'h00);
        rd(2'd1, "R1 dat", 8'h00);
        chk("R1 oe", pin_oe, 8'h00);

        // R2: write and read back
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h5C);
        rd(2'd0, "R2 dir", 8'hFF);
        rd(2'd1, "R2 dat", 8'h5C);
        chk("R2 pins driven", pin_out, 8'h5C);

        // R3: mixed read, R4: sync latency
        pin_in = 8'h3C;
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'hA5);
        tick();
        rd(2'd1, "R3 mixed", 8'h35);
        pin_in = 8'hC3;
        tick();
        rd(2'd1, "R4 after one edge", 8'h35);
        tick();
        rd(2'd1, "R4 after two edges", 8'hC5);

        // R5/R6/R7 sweep: each pin gets its own rotating configuration
        pin_in = 8'h5A;
        tick(); tick();
        wr(2'd1, 8'hC3);
        for (int c = 0; c < 64; c++) begin
            logic [7:0] dd, eo, ee, ec;
            for (int i = 0; i < W; i++) begin
                logic [5:0] k;
                k = 6'((c + i * 9) % 64);
                tmr_pwm[i]       = k[0];
                tmr_ioc[3*i +: 3] = k[3:1];
                pulse_en[i]      = k[4];
                dd[i]            = k[5];
            end
            tmr_out   = 8'(c * 37);
            pulse_val = ~tmr_out ^ 8'h0F;
            wr(2'd0, dd);
            for (int i = 0; i < W; i++) begin
                logic [2:0] r;
                r = pin_exp(6'((c + i * 9) % 64), 8'hC3 >> i, tmr_out[i], pulse_val[i], pin_in[i]);
                eo[i] = r[0]; ee[i] = r[1]; ec[i] = r[2];
            end
            chk("R5/R6 pin_out", pin_out, eo);
            chk("R5/R6 pin_oe", pin_oe, ee);
            chk("R7 cap_in", cap_in, ec);
        end

        // R7: capture input follows pin with two-edge delay
        tmr_pwm = '0;
        tmr_ioc = {8{3'b100}};
        pin_in = 8'hE1;
        tick();
        chk("R7 cap old", cap_in, 8'h5A);
        tick();
        chk("R7 cap new", cap_in, 8'hE1);

        // R8: software standby keeps registers and drive
        tmr_ioc = '0;
        pulse_en = '0;
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'h96);
        sstby = 1'b1;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        chk("R8 drive kept out", pin_out, 8'h90);
        chk("R8 drive kept oe", pin_oe, 8'hF0);
        rd(2'd0, "R8 dir kept", 8'hF0);
        sstby = 1'b0;
        tick();
        rd(2'd1, "R8 dat kept", 8'h96 & 8'hF0 | pin_in & 8'h0F);

        // R9/R10: hardware standby with software standby also high
        tmr_pwm = 8'h01;
        tmr_out = 8'hFF;
        hstby = 1'b1;
        sstby = 1'b1;
        tick();
        chk("R9 oe off", pin_oe, 8'h00);
        chk("R10 hard wins out", pin_out, 8'h00);
        wr(2'd0, 8'hAA);
        rd(2'd0, "R9 write ignored", 8'h00);
        hstby = 1'b0;
        sstby = 1'b0;
        tmr_pwm = '0;
        tick(); tick();
        rd(2'd0, "R10 dir cleared", 8'h00);
        rd(2'd1, "R10 dat reads pins", pin_in);
        wr(2'd0, 8'h0F);
        rd(2'd0, "R10 writes resume", 8'h0F);
        chk("R10 oe resumes", pin_oe, 8'h0F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule